// File: doc/BRIEF.md
# Extended-Precision Underflow Exponent Wrapper and Flag Unit

This block sits at the tail of an extended-precision floating-point datapath and handles results that fall below the normalized range. For each finished operation it takes the 17-bit two's-complement unbiased exponent of the intermediate result. It produces the 15-bit exponent that an underflow trap handler would receive. To get that value, the block adds the ordinary format bias (16383) and an extra wrap offset (24576), 40959 in total, and keeps the low 15 bits. Results so small that this wrap would be meaningless are clamped to an exponent of zero.

Two underflow indications are kept, because enabled and disabled traps follow different rules. A per-operation exception bit reports tininess alone and is rewritten by every operation. A sticky accrued bit requires tininess together with inexactness and stays set until software-style clearing through a dedicated strobe. A one-cycle trap request fires when the trap is enabled and the result is tiny. A combinational recovery output undoes the rebias, so a handler-side check can rebuild the original 17-bit exponent.

The result interface is a plain valid strobe with no ready: the block accepts a new operation on every cycle, so there is never back-pressure, and back-to-back strobes each yield their own registered result one cycle later.

Top module: `uflw_unit`

## Requirements
- R1: While and after reset, with no strobe yet, `exc_exp`, `unfl_exc`, `unfl_acc` and `trap_req` are all 0.
- R2: One cycle after `res_vld` with `exp_in` greater than -40959 (signed), `exc_exp` equals the low 15 bits of `exp_in + 40959`; between strobes `exc_exp` holds its value.
- R3: One cycle after `res_vld` with `exp_in` at or below -40959 (17-bit pattern 0x16001 or any more negative value), `exc_exp` is 0x0000.
- R4: The extreme non-clamped values are exact: -40958 gives 0x0001, -16384 (pattern 0x1C000) gives 0x5FFF.
- R5: A result is tiny only when `fin_q` is 1 and `exp_in` is below -16382 (signed); -16382 itself is not tiny, and with `fin_q` at 0 no exponent is tiny.
- R6: One cycle after each `res_vld`, `unfl_exc` equals the tininess of that operation, set or cleared regardless of `inexact`; it holds between strobes.
- R7: `unfl_acc` becomes 1 one cycle after a `res_vld` that is tiny and `inexact`, stays 1 across later operations until `acc_clr`, and a tiny exact result never sets it. When `acc_clr` and a setting operation occur in the same cycle, the bit ends up 1.
- R8: `trap_req` is 1 for exactly the cycle after a `res_vld` that is tiny while `trap_en` is 1, and is 0 otherwise, including for tiny results with `trap_en` at 0.
- R9: `rec_exp` equals the zero-extended `exc_exp` minus 40959, modulo 2^17, so for every tiny exponent above -40959 it equals the exponent that was presented.
- R10: Strobes on consecutive cycles are each accepted and each produce their own result on the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| res_vld | input | 1 | One-cycle strobe: a finished result is presented |
| exp_in | input | 17 | Unbiased intermediate exponent, two's complement |
| fin_q | input | 1 | Result is a finite non-zero value that may be tiny |
| inexact | input | 1 | Rounder lost accuracy on this result |
| trap_en | input | 1 | Underflow trap enable |
| acc_clr | input | 1 | Clears the accrued underflow bit |
| exc_exp | output | 15 | Rebiased, wrapped or clamped exponent for the handler |
| unfl_exc | output | 1 | Per-operation underflow exception bit |
| unfl_acc | output | 1 | Sticky accrued underflow bit |
| trap_req | output | 1 | One-cycle underflow trap request |
| rec_exp | output | 17 | Exponent recovered from `exc_exp` by removing the combined bias |

## Verification
Every piece of state here is visible one cycle after the strobe that wrote it. A wrong bias or clamp shows as a bad `exc_exp` and a bad `rec_exp` on the next cycle. A lost or spurious accrued bit stays wrong at `unfl_acc` on every later cycle until the next clear, so the per-clock model comparison catches it immediately and keeps reporting it. A trap register that fails to drop shows as a second `trap_req` cycle right after the first.

// File: rtl/uflw_pkg.sv
package uflw_pkg;
  localparam int UF_EXP_W    = 17;
  localparam int UF_FLD_W    = 15;
  localparam int UF_FMT_BIAS = 16383;
  localparam int UF_WRAP_ADJ = 24576;
  localparam int UF_MIN_NORM = -16382;

  typedef struct packed {
    logic tiny;
    logic cata;
  } uf_class_t;
endpackage

// File: rtl/uflw_classify.sv
module uflw_classify #(
  parameter int EXP_W    = uflw_pkg::UF_EXP_W,
  parameter int MIN_NORM = uflw_pkg::UF_MIN_NORM
) (
  input  logic [EXP_W-1:0] exp_in,
  input  logic             fin_q,
  output logic             tiny
);
  localparam logic signed [EXP_W-1:0] MIN_V = EXP_W'(MIN_NORM);

  // tininess is judged on the exponent before rounding
  always_comb tiny = fin_q & ($signed(exp_in) < MIN_V);
endmodule

// File: rtl/uflw_rebias.sv
module uflw_rebias #(
  parameter int EXP_W    = uflw_pkg::UF_EXP_W,
  parameter int FLD_W    = uflw_pkg::UF_FLD_W,
  parameter int BIAS_SUM = uflw_pkg::UF_FMT_BIAS + uflw_pkg::UF_WRAP_ADJ
) (
  input  logic [EXP_W-1:0] exp_in,
  output logic [FLD_W-1:0] fld,
  output logic             cata
);
  localparam logic signed [EXP_W-1:0] CATA_V = EXP_W'(-BIAS_SUM);
  localparam logic [FLD_W-1:0]        ADJ_V  = FLD_W'(BIAS_SUM);

  logic [FLD_W-1:0] low_sum;

  // only the low bits survive the wrap, so the adder is field-wide
  always_comb low_sum = exp_in[FLD_W-1:0] + ADJ_V;
  always_comb cata    = ($signed(exp_in) <= CATA_V);
  always_comb fld     = cata ? '0 : low_sum;
endmodule

// File: rtl/uflw_recover.sv
module uflw_recover #(
  parameter int EXP_W    = uflw_pkg::UF_EXP_W,
  parameter int FLD_W    = uflw_pkg::UF_FLD_W,
  parameter int BIAS_SUM = uflw_pkg::UF_FMT_BIAS + uflw_pkg::UF_WRAP_ADJ
) (
  input  logic [FLD_W-1:0] fld,
  output logic [EXP_W-1:0] rec
);
  localparam logic [EXP_W-1:0] BIAS_V = EXP_W'(BIAS_SUM);

  always_comb rec = {{(EXP_W-FLD_W){1'b0}}, fld} - BIAS_V;
endmodule

// File: rtl/uflw_flags.sv
module uflw_flags #(
  parameter int FLD_W = uflw_pkg::UF_FLD_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             res_vld,
  input  logic             acc_clr,
  input  logic             inexact,
  input  logic             trap_en,
  input  uflw_pkg::uf_class_t cls,
  input  logic [FLD_W-1:0] fld,
  output logic [FLD_W-1:0] exp_q,
  output logic             exc_q,
  output logic             acc_q,
  output logic             trap_q
);
  logic set_acc;
  always_comb set_acc = res_vld & cls.tiny & inexact;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exp_q  <= '0;
      exc_q  <= 1'b0;
      acc_q  <= 1'b0;
      trap_q <= 1'b0;
    end else begin
      trap_q <= res_vld & cls.tiny & trap_en;
      if (res_vld) begin
        exp_q <= fld;
        exc_q <= cls.tiny;
      end
      // a fresh event is never lost to a simultaneous clear
      if (set_acc)      acc_q <= 1'b1;
      else if (acc_clr) acc_q <= 1'b0;
    end
  end

  AST_EXP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !res_vld |=> $stable(exp_q)); // R2
  AST_EXC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !res_vld |=> $stable(exc_q)); // R6
  AST_ACC_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (res_vld && cls.tiny && inexact) |=> acc_q); // R7
  AST_ACC_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_q && !acc_clr) |=> acc_q); // R7
  AST_TRAP_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    (!trap_en || !res_vld) |=> !trap_q); // R8
  AST_TRAP_WITH_EXC: assert property (@(posedge clk) disable iff (!rst_n)
    trap_q |-> exc_q); // R8
endmodule

// File: rtl/uflw_unit.sv
module uflw_unit #(
  parameter int EXP_W    = uflw_pkg::UF_EXP_W,
  parameter int FLD_W    = uflw_pkg::UF_FLD_W,
  parameter int BIAS_SUM = uflw_pkg::UF_FMT_BIAS + uflw_pkg::UF_WRAP_ADJ,
  parameter int MIN_NORM = uflw_pkg::UF_MIN_NORM
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             res_vld,
  input  logic [EXP_W-1:0] exp_in,
  input  logic             fin_q,
  input  logic             inexact,
  input  logic             trap_en,
  input  logic             acc_clr,
  output logic [FLD_W-1:0] exc_exp,
  output logic             unfl_exc,
  output logic             unfl_acc,
  output logic             trap_req,
  output logic [EXP_W-1:0] rec_exp
);
  localparam logic signed [EXP_W-1:0] CATA_LIM = EXP_W'(-BIAS_SUM);
  localparam logic signed [EXP_W-1:0] TINY_LIM = EXP_W'(MIN_NORM);

  uflw_pkg::uf_class_t cls;
  logic [FLD_W-1:0]    fld;

  uflw_classify #(.EXP_W(EXP_W), .MIN_NORM(MIN_NORM)) u_cls (
    .exp_in (exp_in),
    .fin_q  (fin_q),
    .tiny   (cls.tiny)
  );

  uflw_rebias #(.EXP_W(EXP_W), .FLD_W(FLD_W), .BIAS_SUM(BIAS_SUM)) u_rb (
    .exp_in (exp_in),
    .fld    (fld),
    .cata   (cls.cata)
  );

  uflw_flags #(.FLD_W(FLD_W)) u_flg (
    .clk     (clk),
    .rst_n   (rst_n),
    .res_vld (res_vld),
    .acc_clr (acc_clr),
    .inexact (inexact),
    .trap_en (trap_en),
    .cls     (cls),
    .fld     (fld),
    .exp_q   (exc_exp),
    .exc_q   (unfl_exc),
    .acc_q   (unfl_acc),
    .trap_q  (trap_req)
  );

  uflw_recover #(.EXP_W(EXP_W), .FLD_W(FLD_W), .BIAS_SUM(BIAS_SUM)) u_rc (
    .fld (exc_exp),
    .rec (rec_exp)
  );

  AST_CATA_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (res_vld && ($signed(exp_in) <= CATA_LIM)) |=> (exc_exp == '0)); // R3
  AST_ROUND_TRIP: assert property (@(posedge clk) disable iff (!rst_n)
    (res_vld && ($signed(exp_in) > CATA_LIM) && ($signed(exp_in) < TINY_LIM))
      |=> (rec_exp == $past(exp_in))); // R9
endmodule

// File: tb/tb_uflw_unit.sv
`timescale 1ns/1ps
module tb_uflw_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        res_vld = 1'b0;
  logic [16:0] exp_in = '0;
  logic        fin_q = 1'b0;
  logic        inexact = 1'b0;
  logic        trap_en = 1'b0;
  logic        acc_clr = 1'b0;
  logic [14:0] exc_exp;
  logic        unfl_exc, unfl_acc, trap_req;
  logic [16:0] rec_exp;

  int total = 0;
  int fails = 0;
  bit done = 1'b0;
  bit cmp_en = 1'b0;

  // reference model state
  int m_fld, m_ev;
  bit m_exc, m_acc, m_trap, m_tiny;

  always #2 clk = ~clk;

  uflw_unit dut (
    .clk(clk), .rst_n(rst_n), .res_vld(res_vld), .exp_in(exp_in),
    .fin_q(fin_q), .inexact(inexact), .trap_en(trap_en), .acc_clr(acc_clr),
    .exc_exp(exc_exp), .unfl_exc(unfl_exc), .unfl_acc(unfl_acc),
    .trap_req(trap_req), .rec_exp(rec_exp)
  );

  task automatic chk(string req, int a, int e);
    total++;
    if (a != e) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, a, e);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_fld = 0; m_exc = 0; m_acc = 0; m_trap = 0;
    end else begin
      m_ev   = int'($signed(exp_in));
      m_tiny = fin_q && (m_ev < -16382);
      m_trap = res_vld && m_tiny && trap_en;
      if (res_vld) begin
        m_exc = m_tiny;
        m_fld = (m_ev <= -40959) ? 0 : ((m_ev + 40959) & 32'h7FFF);
      end
      if (res_vld && m_tiny && inexact) m_acc = 1;
      else if (acc_clr) m_acc = 0;
    end
  end

  always @(negedge clk) begin
    if (cmp_en && rst_n) begin
      chk("R2 model exc_exp", int'(exc_exp), m_fld);
      chk("R6 model unfl_exc", int'(unfl_exc), int'(m_exc));
      chk("R7 model unfl_acc", int'(unfl_acc), int'(m_acc));
      chk("R8 model trap_req", int'(trap_req), int'(m_trap));
      chk("R9 model rec_exp", int'(rec_exp), (m_fld - 40959) & 32'h1FFFF);
    end
  end

  task automatic op(int e, bit f, bit ix, bit te, bit clr);
    res_vld = 1'b1; exp_in = 17'(e); fin_q = f; inexact = ix;
    trap_en = te; acc_clr = clr;
    @(negedge clk);
    res_vld = 1'b0; acc_clr = 1'b0;
  endtask

  task automatic idle(bit clr);
    res_vld = 1'b0; acc_clr = clr;
    @(negedge clk);
    acc_clr = 1'b0;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog: actual running expected finished");
      summary();
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    chk("R1 exc_exp in reset", int'(exc_exp), 0);
    chk("R1 trap_req in reset", int'(trap_req), 0);
    rst_n = 1'b1;
    @(negedge clk);
    cmp_en = 1'b1;
    chk("R1 exc_exp", int'(exc_exp), 0);
    chk("R1 unfl_exc", int'(unfl_exc), 0);
    chk("R1 unfl_acc", int'(unfl_acc), 0);
    chk("R1 trap_req", int'(trap_req), 0);

    op(-16384, 1, 0, 1, 0);
    chk("R4 top of wrap range", int'(exc_exp), 'h5FFF);
    chk("R6 tiny exact sets exc", int'(unfl_exc), 1);
    chk("R8 trap pulse", int'(trap_req), 1);
    chk("R7 exact leaves acc", int'(unfl_acc), 0);
    chk("R9 recover top", int'(rec_exp), 'h1C000);
    idle(0);
    chk("R8 trap drops", int'(trap_req), 0);
    chk("R6 exc holds", int'(unfl_exc), 1);
    chk("R2 exp holds", int'(exc_exp), 'h5FFF);

    op(-40959, 1, 0, 0, 0);
    chk("R3 clamp at limit", int'(exc_exp), 0);
    op(-40960, 1, 0, 0, 0);
    chk("R3 clamp below limit", int'(exc_exp), 0);
    op(-65536, 1, 0, 0, 0);
    chk("R3 clamp most negative", int'(exc_exp), 0);
    op(-40958, 1, 0, 0, 0);
    chk("R4 bottom of wrap range", int'(exc_exp), 1);
    chk("R9 recover bottom", int'(rec_exp), 'h16002);
    chk("R8 no trap when disabled", int'(trap_req), 0);

    op(-16382, 1, 1, 1, 0);
    chk("R5 min normal not tiny", int'(unfl_exc), 0);
    chk("R8 no trap for normal", int'(trap_req), 0);
    op(-16383, 1, 0, 0, 0);
    chk("R5 just below min tiny", int'(unfl_exc), 1);
    op(-20000, 0, 1, 1, 0);
    chk("R5 qualifier low not tiny", int'(unfl_exc), 0);
    chk("R7 qualifier low no acc", int'(unfl_acc), 0);
    chk("R2 rebias mid", int'(exc_exp), 20959);
    op(100, 1, 0, 0, 0);
    chk("R2 rebias positive wraps", int'(exc_exp), 8291);

    op(-30000, 1, 1, 0, 0);
    chk("R7 tiny inexact sets acc", int'(unfl_acc), 1);
    op(5, 1, 0, 0, 0);
    op(-100, 1, 1, 0, 0);
    chk("R7 acc sticky", int'(unfl_acc), 1);
    chk("R6 exc cleared by normal op", int'(unfl_exc), 0);
    idle(1);
    chk("R7 clear", int'(unfl_acc), 0);
    op(-30000, 1, 1, 0, 1);
    chk("R7 set beats clear", int'(unfl_acc), 1);
    idle(1);

    op(-16384, 1, 0, 1, 0);
    chk("R10 first of pair", int'(exc_exp), 'h5FFF);
    op(-16385, 1, 0, 1, 0);
    chk("R10 second of pair", int'(exc_exp), 'h5FFE);
    chk("R10 second trap", int'(trap_req), 1);

    for (int i = 0; i < 4000; i++) begin
      int r, e;
      r = int'($urandom_range(0, 3));
      case (r)
        0: e = int'($urandom_range(0, 131071)) - 65536;
        1: e = -40959 + int'($urandom_range(0, 4)) - 2;
        2: e = -16382 + int'($urandom_range(0, 4)) - 2;
        default: e = -40958 + int'($urandom_range(0, 24575));
      endcase
      res_vld = ($urandom_range(0, 3) != 0);
      exp_in  = 17'(e);
      fin_q   = ($urandom_range(0, 7) != 0);
      inexact = $urandom_range(0, 1) != 0;
      trap_en = $urandom_range(0, 1) != 0;
      acc_clr = ($urandom_range(0, 9) == 0);
      @(negedge clk);
    end
    res_vld = 1'b0; acc_clr = 1'b0;
    @(negedge clk);
    done = 1'b1;
    summary();
  end
endmodule